// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Tag Lookup

This block is the tag side of a cache whose set is picked from the virtual address while the address translation runs alongside it. The set index covers the untranslated 12-bit page offset and also the lowest 8 bits of the virtual page number. Each set can therefore hold lines from one page colour only, and the cache can grow beyond page size times associativity. In the first cycle a lookup reads every way of the chosen set into a register. In the second cycle the physical frame number from the translation unit is compared against those registered tags. The block reports a hit and the hitting way.

A mapping is alias-free only when the low 8 bits of the physical frame number equal the low 8 bits of the virtual page number. When they differ, the block flags a colour error instead of a hit. A stored tag is the frame number with its colour bits removed, because the set position already implies those bits. A fill port writes a tag into the lowest-numbered invalid way of a set. When the set is full, the fill goes to the way named by that set's round-robin pointer. After reset, an internal sweep clears the valid bits and pointers one set per cycle, and `busy` stays high for the whole sweep.

Top module: `vipt_tag_lookup`

## Requirements
- R1: `busy` is high while `rst` is high. After `rst` is released, `busy` stays high for exactly SETS rising edges and is low from then on. SETS = 2^(PAGE_BITS+COLOUR_BITS-LINE_BITS).
- R2: After the sweep finishes, every lookup returns `res_valid`=1 with `res_hit`=0 and `res_way`=0 until a fill is made.
- R3: While `busy` is high, a lookup produces no result (`res_valid` stays 0 in the next cycle), and a fill is dropped, so a later lookup of that line misses.
- R4: A lookup accepted in cycle N produces `res_valid`=1 only in cycle N+1. The result is formed from the `xl_pfn` and `xl_fault` values present in cycle N+1.
- R5: A hit requires a valid way whose stored tag equals `xl_pfn` bits above the low COLOUR_BITS. `res_way` is then one-hot with bit w set for way w, assuming tags within a set are distinct. A different tag misses with `res_way`=0.
- R6: The set index is virtual address bits [PAGE_BITS+COLOUR_BITS-1 : LINE_BITS]. Addresses that differ only in the line offset bits [LINE_BITS-1:0] select the same set. Addresses that differ in any index bit select different sets.
- R7: When `xl_pfn[COLOUR_BITS-1:0]` differs from virtual address bits [PAGE_BITS+COLOUR_BITS-1 : PAGE_BITS], `res_colour_err`=1 and `res_hit`=0. When they are equal, `res_colour_err`=0.
- R8: When `xl_fault`=1 in the result cycle, `res_valid` stays 1 while `res_hit`, `res_way` and `res_colour_err` are all 0.
- R9: A fill writes the lowest-numbered invalid way of its set, so fills into an empty set use ways 0, 1, 2, … in order.
- R10: A fill into a set with all ways valid writes the way named by that set's pointer. The pointer is 0 after the sweep, advances by one modulo WAYS on each such fill, and is left unchanged by fills that find an invalid way.
- R11: A lookup and a fill to the same set in the same cycle: the lookup sees the set contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| busy | output | 1 | High while the valid and pointer state is being cleared |
| lk_valid | input | 1 | Lookup request in the first pipeline cycle |
| lk_vaddr | input | VA_BITS | Virtual address of the lookup |
| xl_pfn | input | PA_BITS-PAGE_BITS | Translated frame number, presented in the cycle after the lookup |
| xl_fault | input | 1 | Translation fault, presented with `xl_pfn` |
| fill_valid | input | 1 | Fill request |
| fill_vaddr | input | VA_BITS | Virtual address whose set receives the fill |
| fill_pfn | input | PA_BITS-PAGE_BITS | Frame number of the filled line |
| res_valid | output | 1 | Lookup result present this cycle |
| res_hit | output | 1 | Lookup hit |
| res_way | output | WAYS | One-hot hitting way |
| res_colour_err | output | 1 | Frame colour disagrees with virtual page colour |

## Verification
The bench builds the block with WAYS=4 and LINE_BITS=10. All other parameters keep their defaults: a 32-bit address, 4 KB pages and 8 colour bits, which gives 1024 sets. Four ways let the fill order walk through several invalid ways and then show the pointer moving through a full set. The default sizes keep the real 20-bit index split, so colour mismatches and neighbouring-set misses use true bit positions. The 1024-cycle sweep is short enough to run twice, once to measure `busy` and once to show that fills and lookups issued during the sweep are dropped.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;

    typedef enum logic {
        CLR_SWEEP = 1'b0,
        CLR_DONE  = 1'b1
    } clr_state_e;

    // Advance a ring pointer by one, wrapping at n.
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/vipt_clear_seq.sv
`timescale 1ns/1ps
module vipt_clear_seq #(
    parameter int SETS  = 1024,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             busy,
    output logic [IDX_W-1:0] clr_idx
);
    import vipt_pkg::*;

    clr_state_e state_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CLR_SWEEP;
            cnt_q   <= '0;
        end else if (state_q == CLR_SWEEP) begin
            if (cnt_q == IDX_W'(SETS - 1)) begin
                state_q <= CLR_DONE;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy    = (state_q == CLR_SWEEP);
    assign clr_idx = cnt_q;

endmodule

// File: rtl/vipt_tag_store.sv
`timescale 1ns/1ps
module vipt_tag_store #(
    parameter int SETS  = 1024,
    parameter int WAYS  = 2,
    parameter int TAG_W = 12,
    localparam int IDX_W = $clog2(SETS),
    localparam int PTR_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [TAG_W-1:0]            fill_tag,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_vld
);
    import vipt_pkg::*;

    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];
    logic [PTR_W-1:0]           ptr_q [SETS];

    logic [PTR_W-1:0] victim;
    logic             has_free;

    // Lowest invalid way wins; otherwise the set's round-robin pointer.
    always_comb begin
        victim   = ptr_q[fill_idx];
        has_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[fill_idx][w]) begin
                victim   = PTR_W'(w);
                has_free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            vld_q[clr_idx] <= '0;
            ptr_q[clr_idx] <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx][victim] <= 1'b1;
            if (!has_free) begin
                ptr_q[fill_idx] <= PTR_W'(ring_next(32'(ptr_q[fill_idx]), WAYS));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !clr_en) begin
            tag_q[fill_idx][victim] <= fill_tag;
        end
    end

    // Stage-1 register: all ways of the indexed set, read before any same-cycle fill.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag <= tag_q[rd_idx];
            rd_vld <= vld_q[rd_idx];
        end
    end

endmodule

// File: rtl/vipt_way_compare.sv
`timescale 1ns/1ps
module vipt_way_compare #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 12,
    parameter int COL_W = 8,
    localparam int PFN_W = TAG_W + COL_W
) (
    input  logic                       s2_valid,
    input  logic [COL_W-1:0]           s2_colour,
    input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    input  logic [WAYS-1:0]            rd_vld,
    input  logic [PFN_W-1:0]           xl_pfn,
    input  logic                       xl_fault,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic [WAYS-1:0]            res_way,
    output logic                       res_colour_err
);
    logic [WAYS-1:0] match;
    logic            colour_ok;
    logic            usable;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = rd_vld[w] && (rd_tag[w] == xl_pfn[PFN_W-1:COL_W]);
    end

    assign colour_ok      = (xl_pfn[COL_W-1:0] == s2_colour);
    assign usable         = s2_valid && !xl_fault;
    assign res_valid      = s2_valid;
    assign res_way        = (usable && colour_ok) ? match : '0;
    assign res_hit        = |res_way;
    assign res_colour_err = usable && !colour_ok;

endmodule

// File: rtl/vipt_tag_lookup.sv
`timescale 1ns/1ps
module vipt_tag_lookup #(
    parameter int VA_BITS     = 32,
    parameter int PA_BITS     = 32,
    parameter int PAGE_BITS   = 12,
    parameter int COLOUR_BITS = 8,
    parameter int LINE_BITS   = 10,
    parameter int WAYS        = 2,
    localparam int PFN_W = PA_BITS - PAGE_BITS,
    localparam int TAG_W = PFN_W - COLOUR_BITS,
    localparam int IDX_W = PAGE_BITS + COLOUR_BITS - LINE_BITS,
    localparam int SETS  = 1 << IDX_W,
    localparam int IDX_HI = PAGE_BITS + COLOUR_BITS - 1
) (
    input  logic               clk,
    input  logic               rst,
    output logic               busy,
    input  logic               lk_valid,
    input  logic [VA_BITS-1:0] lk_vaddr,
    input  logic [PFN_W-1:0]   xl_pfn,
    input  logic               xl_fault,
    input  logic               fill_valid,
    input  logic [VA_BITS-1:0] fill_vaddr,
    input  logic [PFN_W-1:0]   fill_pfn,
    output logic               res_valid,
    output logic               res_hit,
    output logic [WAYS-1:0]    res_way,
    output logic               res_colour_err
);
    logic [IDX_W-1:0]           clr_idx;
    logic                       lk_go, fill_go;
    logic                       s2_valid_q;
    logic [COLOUR_BITS-1:0]     s2_colour_q;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_vld;

    logic unused_bits;
    assign unused_bits = ^{lk_vaddr[VA_BITS-1:IDX_HI+1], lk_vaddr[LINE_BITS-1:0],
                           fill_vaddr[VA_BITS-1:IDX_HI+1], fill_vaddr[LINE_BITS-1:0],
                           fill_pfn[COLOUR_BITS-1:0]};

    assign lk_go   = lk_valid && !busy;
    assign fill_go = fill_valid && !busy;

    vipt_clear_seq #(.SETS(SETS)) u_clear (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .clr_idx (clr_idx)
    );

    vipt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .clr_en   (busy),
        .clr_idx  (clr_idx),
        .rd_en    (lk_go),
        .rd_idx   (lk_vaddr[IDX_HI:LINE_BITS]),
        .fill_en  (fill_go),
        .fill_idx (fill_vaddr[IDX_HI:LINE_BITS]),
        .fill_tag (fill_pfn[PFN_W-1:COLOUR_BITS]),
        .rd_tag   (rd_tag),
        .rd_vld   (rd_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid_q <= 1'b0;
        end else begin
            s2_valid_q <= lk_go;
        end
    end

    always_ff @(posedge clk) begin
        if (lk_go) begin
            s2_colour_q <= lk_vaddr[IDX_HI:PAGE_BITS];
        end
    end

    vipt_way_compare #(.WAYS(WAYS), .TAG_W(TAG_W), .COL_W(COLOUR_BITS)) u_cmp (
        .s2_valid       (s2_valid_q),
        .s2_colour      (s2_colour_q),
        .rd_tag         (rd_tag),
        .rd_vld         (rd_vld),
        .xl_pfn         (xl_pfn),
        .xl_fault       (xl_fault),
        .res_valid      (res_valid),
        .res_hit        (res_hit),
        .res_way        (res_way),
        .res_colour_err (res_colour_err)
    );

endmodule

// File: rtl/vipt_tag_lookup_chk.sv
`timescale 1ns/1ps
module vipt_tag_lookup_chk #(
    parameter int WAYS = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            lk_valid,
    input logic            xl_fault,
    input logic            res_valid,
    input logic            res_hit,
    input logic [WAYS-1:0] res_way,
    input logic            res_colour_err
);
    // R1: the sweep is running in the first cycle after reset is released.
    p_busy_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);

    // R3: a lookup seen during the sweep yields no result.
    p_no_result_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !res_valid);

    // R4: a result only follows a lookup request one cycle earlier.
    p_result_follows_lookup_r4: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(lk_valid));

    // R5: a hit names exactly one way.
    p_way_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> ($countones(res_way) == 1));

    // R7: a colour error never coexists with a hit.
    p_colour_nohit_r7: assert property (@(posedge clk) disable iff (rst)
        res_colour_err |-> (!res_hit && res_way == '0));

    // R8: a faulting translation reports neither hit nor colour error.
    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && xl_fault) |-> (!res_hit && !res_colour_err && res_way == '0));

endmodule

bind vipt_tag_lookup vipt_tag_lookup_chk #(.WAYS(WAYS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .lk_valid       (lk_valid),
    .xl_fault       (xl_fault),
    .res_valid      (res_valid),
    .res_hit        (res_hit),
    .res_way        (res_way),
    .res_colour_err (res_colour_err)
);

// File: tb/vipt_tag_lookup_bench.sv
`timescale 1ns/1ps
module vipt_tag_lookup_bench;
    localparam int WAYS  = 4;
    localparam int LINE  = 10;
    localparam int SETS  = 1 << (12 + 8 - LINE);
    localparam int PFN_W = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             busy;
    logic             lk_valid = 1'b0;
    logic [31:0]      lk_vaddr = '0;
    logic [PFN_W-1:0] xl_pfn = '0;
    logic             xl_fault = 1'b0;
    logic             fill_valid = 1'b0;
    logic [31:0]      fill_vaddr = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic             res_valid, res_hit, res_colour_err;
    logic [WAYS-1:0]  res_way;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vipt_tag_lookup #(.LINE_BITS(LINE), .WAYS(WAYS)) u_vipt_tag_lookup (
        .clk(clk), .rst(rst), .busy(busy),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .xl_pfn(xl_pfn), .xl_fault(xl_fault),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_pfn(fill_pfn),
        .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
        .res_colour_err(res_colour_err)
    );

    function automatic logic [31:0] va(input logic [7:0] col, input logic [1:0] lo, input logic [9:0] off);
        return {12'h000, col, lo, off};
    endfunction

    function automatic logic [PFN_W-1:0] pf(input logic [11:0] tag, input logic [7:0] col);
        return {tag, col};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] a, input logic [PFN_W-1:0] p);
        fill_valid = 1'b1; fill_vaddr = a; fill_pfn = p;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Lookup in cycle N, translation in N+1, result sampled in N+1.
    task automatic look(input logic [31:0] a, input logic [PFN_W-1:0] p, input logic flt,
                        output logic rv, output logic h, output logic [WAYS-1:0] w, output logic ce);
        lk_valid = 1'b1; lk_vaddr = a; xl_pfn = ~p; xl_fault = ~flt;
        @(negedge clk);
        lk_valid = 1'b0; xl_pfn = p; xl_fault = flt;
        #1;
        rv = res_valid; h = res_hit; w = res_way; ce = res_colour_err;
    endtask

    task automatic expect_look(input string req, input logic [31:0] a, input logic [PFN_W-1:0] p,
                               input logic flt, input logic eh, input logic [WAYS-1:0] ew, input logic ece);
        logic rv, h, ce;
        logic [WAYS-1:0] w;
        look(a, p, flt, rv, h, w, ce);
        chk(req, "res_valid", 32'(rv), 32'd1);
        chk(req, "res_hit", 32'(h), 32'(eh));
        chk(req, "res_way", 32'(w), 32'(ew));
        chk(req, "res_colour_err", 32'(ce), 32'(ece));
    endtask

    task automatic t_reset_sweep;
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "busy during reset", 32'(busy), 32'd1);
        rst = 1'b0;
        n = 0;
        while (busy === 1'b1 && n < SETS + 10) begin
            @(negedge clk);
            n++;
        end
        chk("R1", "busy length", 32'(n), 32'(SETS));
        @(negedge clk);
        chk("R1", "busy stays low", 32'(busy), 32'd0);
    endtask

    task automatic t_empty_miss;
        expect_look("R2", va(8'h12, 2'd0, 10'h000), pf(12'h111, 8'h12), 1'b0, 1'b0, 4'b0000, 1'b0);
        expect_look("R2", va(8'hFF, 2'd3, 10'h3FF), pf(12'hFFF, 8'hFF), 1'b0, 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_hit_basic;
        fill(va(8'h12, 2'd0, 10'h040), pf(12'h111, 8'h12));
        expect_look("R5", va(8'h12, 2'd0, 10'h000), pf(12'h111, 8'h12), 1'b0, 1'b1, 4'b0001, 1'b0);
        @(negedge clk); #1;
        chk("R4", "result only one cycle", 32'(res_valid), 32'd0);
        expect_look("R6", va(8'h12, 2'd0, 10'h3FF), pf(12'h111, 8'h12), 1'b0, 1'b1, 4'b0001, 1'b0);
        expect_look("R5", va(8'h12, 2'd0, 10'h000), pf(12'h112, 8'h12), 1'b0, 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_index;
        expect_look("R6", va(8'h12, 2'd1, 10'h000), pf(12'h111, 8'h12), 1'b0, 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_colour;
        expect_look("R7", va(8'h12, 2'd0, 10'h000), pf(12'h111, 8'h13), 1'b0, 1'b0, 4'b0000, 1'b1);
    endtask

    task automatic t_fault;
        expect_look("R8", va(8'h12, 2'd0, 10'h000), pf(12'h111, 8'h12), 1'b1, 1'b0, 4'b0000, 1'b0);
        expect_look("R8", va(8'h12, 2'd0, 10'h000), pf(12'h111, 8'h55), 1'b1, 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_fill_order;
        for (int i = 0; i < WAYS; i++) fill(va(8'h40, 2'd2, 10'h000), pf(12'h201 + 12'(i), 8'h40));
        for (int i = 0; i < WAYS; i++)
            expect_look("R9", va(8'h40, 2'd2, 10'h000), pf(12'h201 + 12'(i), 8'h40), 1'b0, 1'b1, 4'(1 << i), 1'b0);
    endtask

    task automatic t_round_robin;
        fill(va(8'h40, 2'd2, 10'h000), pf(12'h205, 8'h40));
        fill(va(8'h40, 2'd2, 10'h000), pf(12'h206, 8'h40));
        expect_look("R10", va(8'h40, 2'd2, 10'h000), pf(12'h205, 8'h40), 1'b0, 1'b1, 4'b0001, 1'b0);
        expect_look("R10", va(8'h40, 2'd2, 10'h000), pf(12'h201, 8'h40), 1'b0, 1'b0, 4'b0000, 1'b0);
        expect_look("R10", va(8'h40, 2'd2, 10'h000), pf(12'h206, 8'h40), 1'b0, 1'b1, 4'b0010, 1'b0);
        expect_look("R10", va(8'h40, 2'd2, 10'h000), pf(12'h203, 8'h40), 1'b0, 1'b1, 4'b0100, 1'b0);
    endtask

    task automatic t_same_cycle;
        fill_valid = 1'b1; fill_vaddr = va(8'h77, 2'd1, 10'h000); fill_pfn = pf(12'h300, 8'h77);
        expect_look("R11", va(8'h77, 2'd1, 10'h000), pf(12'h300, 8'h77), 1'b0, 1'b0, 4'b0000, 1'b0);
        fill_valid = 1'b0;
        expect_look("R11", va(8'h77, 2'd1, 10'h000), pf(12'h300, 8'h77), 1'b0, 1'b1, 4'b0001, 1'b0);
    endtask

    task automatic t_busy_drop;
        logic rv, h, ce;
        logic [WAYS-1:0] w;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        fill(va(8'h00, 2'd0, 10'h000), pf(12'h3AB, 8'h00));
        look(va(8'h00, 2'd0, 10'h000), pf(12'h3AB, 8'h00), 1'b0, rv, h, w, ce);
        chk("R3", "no result while busy", 32'(rv), 32'd0);
        while (busy === 1'b1) @(negedge clk);
        expect_look("R3", va(8'h00, 2'd0, 10'h000), pf(12'h3AB, 8'h00), 1'b0, 1'b0, 4'b0000, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_sweep();
        t_empty_miss();
        t_hit_basic();
        t_index();
        t_colour();
        t_fault();
        t_fill_order();
        t_round_robin();
        t_same_cycle();
        t_busy_drop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule